// File: doc/BRIEF.md
# Bus Block-Transfer Burst Sequencer

This block turns one local DMA request into a series of block-transfer bursts on a simplified bus-master port. Software or a local controller supplies a start address, a total length in bytes, a beat size, a maximum number of beats per burst and an idle interval. It then pulses `start`. The sequencer holds an address strobe for the length of each burst and requests one beat at a time with a data strobe. Every beat that the bus acknowledges moves the address on by the beat size.

A burst ends at the first of three events: the programmed beat count is reached, the next beat would cross a 256-byte address boundary, or the transfer is complete. Between bursts the address strobe is released for a programmed number of idle cycles, so other masters can win the bus. A bus error on any beat abandons the whole transfer. On the local side, each accepted beat raises a one-cycle pulse carrying the byte offset into the transfer, which local memory uses to fetch or store that beat's data.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `bus_as`, `bus_req` and `loc_valid` are all low.
- R2: A `start` pulse while idle latches the configuration. At the next clock edge `busy`, `bus_as` and `bus_req` rise together, and `bus_addr` equals `cfg_addr`.
- R3: A beat is accepted on a clock edge where `bus_req` and `bus_ack` are both high and `bus_berr` is low. `bus_addr` advances by the beat size after each accepted beat and holds steady while a request waits. `cfg_size` encodes the beat size as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R4: `bus_req` is high only while `bus_as` is high.
- R5: Within one assertion of `bus_as`, address bits above bit 7 never change. A burst is cut after the beat that ends at a 256-byte boundary, so no burst carries more than 256 bytes.
- R6: A burst is cut after `cfg_burst` accepted beats when `cfg_burst` is nonzero. The value 0 means the count sets no limit.
- R7: Between two bursts of one transfer, `bus_as` is low for exactly `cfg_gap`+1 cycles. With `cfg_gap` = 0 the strobe is released for a single cycle.
- R8: The transfer ends after the beat on which the remaining length is at most the beat size. On the edge that accepts that beat, `done` pulses for one cycle and `busy`, `bus_as` and `bus_req` fall. The length is assumed to be a multiple of the beat size, with the address aligned to it.
- R9: `bus_berr` with `bus_req` high aborts the transfer. The beat is not counted, `done` pulses and `err` rises, and `err` stays high until the next accepted `start`.
- R10: A `start` with `cfg_len` = 0 produces `done` one edge later with no beat and no bus strobe.
- R11: The edge after each accepted beat raises `loc_valid` for one cycle. `loc_off` then gives that beat's byte offset from the start address.
- R12: `start` while `busy` is ignored and does not disturb the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| cfg_addr | input | ADDR_W | Start byte address |
| cfg_len | input | LEN_W | Total length in bytes |
| cfg_size | input | 2 | Beat size code |
| cfg_burst | input | BURST_W | Maximum beats per burst, 0 = no limit |
| cfg_gap | input | GAP_W | Idle cycles between bursts, minus one |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transfer ended on a bus error |
| bus_as | output | 1 | Address strobe, held for a burst |
| bus_req | output | 1 | Beat request (data strobe) |
| bus_addr | output | ADDR_W | Address of the requested beat |
| bus_ack | input | 1 | Beat acknowledge |
| bus_berr | input | 1 | Bus error for the requested beat |
| loc_valid | output | 1 | Local DMA beat pulse |
| loc_off | output | LEN_W | Byte offset of the local beat |

## Verification
The embedded assertions check several rules on every cycle: the data strobe never appears without the address strobe, the address holds while a request is waiting, the upper address bits stay fixed within one address-strobe assertion, the burst beat counter stays below its limit, and `done` and `err` agree with `busy`. Other properties depend on a whole scenario and are shown only by the bench. These are the exact sequence of beat addresses, the burst split points caused by the count and by the 256-byte boundary, the idle-gap lengths, abort after a chosen beat, the zero-length case, the local offsets and the rejection of a second `start`.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_t;

  // beat size in bytes for a size code
  function automatic logic [2:0] beat_bytes(input logic [1:0] code);
    case (code)
      2'd0:    beat_bytes = 3'd1;
      2'd1:    beat_bytes = 3'd2;
      default: beat_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bts_step_calc.sv
module bts_step_calc #(
  parameter int LEN_W = 16
) (
  input  logic [1:0]       size_code,
  input  logic [7:0]       addr_lo,
  input  logic [LEN_W-1:0] remaining,
  output logic [2:0]       step,
  output logic             page_end,
  output logic             last_beat
);
  import bts_pkg::*;

  logic [8:0] next_lo;

  always_comb begin
    step      = beat_bytes(size_code);
    next_lo   = {1'b0, addr_lo} + {6'd0, step};
    page_end  = next_lo[8];
    last_beat = (remaining <= LEN_W'(step));
  end
endmodule

// File: rtl/bts_burst_ctr.sv
module bts_burst_ctr #(
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               inc,
  input  logic               active,
  input  logic [BURST_W-1:0] limit,
  output logic               limit_hit
);
  logic [BURST_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (inc)     cnt <= cnt + 1'b1;
  end

  assign limit_hit = (limit != '0) && (cnt == limit - 1'b1);

  // R6
  burst_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (active && limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/bts_gap_timer.sv
module bts_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] value,
  input  logic             dec,
  output logic             expired
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= value;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R7
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && !expired) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int BURST_W = 8,
  parameter int GAP_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [1:0]         cfg_size,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [GAP_W-1:0]   cfg_gap,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               bus_as,
  output logic               bus_req,
  output logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_ack,
  input  logic               bus_berr,
  output logic               loc_valid,
  output logic [LEN_W-1:0]   loc_off
);
  import bts_pkg::*;

  seq_state_t         state;
  logic [LEN_W-1:0]   remaining;
  logic [LEN_W-1:0]   offset;
  logic [1:0]         size_q;
  logic [BURST_W-1:0] burst_q;
  logic [GAP_W-1:0]   gap_q;

  logic [2:0] step;
  logic       page_end, last_beat, limit_hit, gap_done;
  logic       accept, abort, launch, cut, restart;

  assign accept  = (state == ST_BEAT) && bus_req && bus_ack && !bus_berr;
  assign abort   = (state == ST_BEAT) && bus_req && bus_berr;
  assign launch  = (state == ST_IDLE) && start && (cfg_len != '0);
  assign cut     = accept && !last_beat && (page_end || limit_hit);
  assign restart = (state == ST_GAP) && gap_done;

  bts_step_calc #(.LEN_W(LEN_W)) u_step (
    .size_code (size_q),
    .addr_lo   (bus_addr[7:0]),
    .remaining (remaining),
    .step      (step),
    .page_end  (page_end),
    .last_beat (last_beat)
  );

  bts_burst_ctr #(.BURST_W(BURST_W)) u_bctr (
    .clk       (clk),
    .rst       (rst),
    .clear     (launch || restart),
    .inc       (accept),
    .active    (state == ST_BEAT),
    .limit     (burst_q),
    .limit_hit (limit_hit)
  );

  bts_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (cut),
    .value   (gap_q),
    .dec     (state == ST_GAP),
    .expired (gap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      remaining <= '0;
      offset    <= '0;
      size_q    <= '0;
      burst_q   <= '0;
      gap_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      bus_as    <= 1'b0;
      bus_req   <= 1'b0;
      bus_addr  <= '0;
      loc_valid <= 1'b0;
      loc_off   <= '0;
    end else begin
      done      <= 1'b0;
      loc_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            err       <= 1'b0;
            size_q    <= cfg_size;
            burst_q   <= cfg_burst;
            gap_q     <= cfg_gap;
            bus_addr  <= cfg_addr;
            remaining <= cfg_len;
            offset    <= '0;
            if (cfg_len == '0) begin
              done <= 1'b1;
            end else begin
              busy    <= 1'b1;
              bus_as  <= 1'b1;
              bus_req <= 1'b1;
              state   <= ST_BEAT;
            end
          end
        end
        ST_BEAT: begin
          if (abort) begin
            err     <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            bus_as  <= 1'b0;
            bus_req <= 1'b0;
            state   <= ST_IDLE;
          end else if (accept) begin
            loc_valid <= 1'b1;
            loc_off   <= offset;
            offset    <= offset + LEN_W'(step);
            bus_addr  <= bus_addr + ADDR_W'(step);
            if (last_beat) begin
              remaining <= '0;
              done      <= 1'b1;
              busy      <= 1'b0;
              bus_as    <= 1'b0;
              bus_req   <= 1'b0;
              state     <= ST_IDLE;
            end else begin
              remaining <= remaining - LEN_W'(step);
              if (cut) begin
                bus_as  <= 1'b0;
                bus_req <= 1'b0;
                state   <= ST_GAP;
              end
            end
          end
        end
        ST_GAP: begin
          if (gap_done) begin
            bus_as  <= 1'b1;
            bus_req <= 1'b1;
            state   <= ST_BEAT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  req_in_as_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_as);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !bus_berr) |=> $stable(bus_addr));

  // R5
  page_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_as && bus_req && bus_ack && !bus_berr) |=>
      (!bus_as || bus_addr[ADDR_W-1:8] == $past(bus_addr[ADDR_W-1:8])));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

  // R11
  loc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && !bus_berr) |=> loc_valid);
endmodule

// File: tb/tb_blk_xfer_seq.sv
`timescale 1ns/1ps
module tb_blk_xfer_seq;
  localparam int ADDR_W = 32, LEN_W = 16, BURST_W = 8, GAP_W = 8;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [ADDR_W-1:0]  cfg_addr = '0;
  logic [LEN_W-1:0]   cfg_len = '0;
  logic [1:0]         cfg_size = '0;
  logic [BURST_W-1:0] cfg_burst = '0;
  logic [GAP_W-1:0]   cfg_gap = '0;
  logic busy, done, err, bus_as, bus_req, loc_valid;
  logic [ADDR_W-1:0] bus_addr;
  logic [LEN_W-1:0]  loc_off;
  logic bus_ack = 1'b0, bus_berr = 1'b0;

  always #2.5 clk = ~clk;

  blk_xfer_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_W(BURST_W), .GAP_W(GAP_W)) dut (
    .clk(clk), .rst(rst), .start(start), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
    .cfg_size(cfg_size), .cfg_burst(cfg_burst), .cfg_gap(cfg_gap),
    .busy(busy), .done(done), .err(err), .bus_as(bus_as), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_berr(bus_berr),
    .loc_valid(loc_valid), .loc_off(loc_off));

  int n_chk = 0, n_bad = 0;
  int unsigned exp_addr [0:1023];
  int          exp_bur  [0:1023];
  int          n_exp, n_exp_bur;
  int unsigned obs_addr [0:1023];
  int          obs_bur  [0:1023];
  int unsigned obs_loc  [0:1023];
  int          obs_gap  [0:63];
  int          n_obs, n_loc, n_gap, bur_idx, low_cnt, wait_cnt, ws, berr_at;
  logic        prev_as, mon_on;
  int unsigned base_addr;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // bench reference model of the burst split
  task automatic build_expect(input int unsigned a0, input int len, input int sz,
                              input int lim);
    int unsigned a = a0;
    int rem = len, bs, b = 0, bur = 0;
    bs = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    n_exp = 0;
    while (rem > 0) begin
      bit last, cut;
      exp_addr[n_exp] = a;
      exp_bur[n_exp]  = bur;
      n_exp++;
      b++;
      last = (rem <= bs);
      cut  = (((a & 255) + bs) >= 256) || (lim != 0 && b == lim);
      a   += bs;
      rem  = last ? 0 : rem - bs;
      if (cut && !last) begin bur++; b = 0; end
    end
    n_exp_bur = bur + 1;
  endtask

  // responder and monitor, all at the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (loc_valid) begin obs_loc[n_loc] = loc_off; n_loc++; end
      if (bus_as && !prev_as) begin
        bur_idx++;
        if (low_cnt > 0) begin obs_gap[n_gap] = low_cnt; n_gap++; end
        low_cnt = 0;
      end
      if (busy && !bus_as) low_cnt++;
      prev_as = bus_as;
      bus_ack  = 1'b0;
      bus_berr = 1'b0;
      if (bus_req) begin
        if (wait_cnt >= ws) begin
          wait_cnt = 0;
          if (berr_at >= 0 && n_obs == berr_at) bus_berr = 1'b1;
          else begin
            bus_ack = 1'b1;
            obs_addr[n_obs] = bus_addr;
            obs_bur[n_obs]  = bur_idx;
            n_obs++;
          end
        end else wait_cnt++;
      end
    end
  end

  task automatic arm_monitor();
    n_obs = 0; n_loc = 0; n_gap = 0; bur_idx = -1; low_cnt = 0;
    wait_cnt = 0; prev_as = 1'b0; mon_on = 1'b1;
  endtask

  task automatic launch(input int unsigned a, input int len, input int sz,
                        input int lim, input int gap);
    @(negedge clk);
    cfg_addr = a; cfg_len = LEN_W'(len); cfg_size = 2'(sz);
    cfg_burst = BURST_W'(lim); cfg_gap = GAP_W'(gap);
    base_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_and_compare(input string req, input int unsigned a, input int len,
                                 input int sz, input int lim, input int gap);
    bit seen, ok;
    int bad_i;
    build_expect(a, len, sz, lim);
    arm_monitor();
    launch(a, len, sz, lim, gap);
    check(busy && bus_as && bus_req && bus_addr == a, "R2", "launch state",
          bus_addr, a);
    wait_done(seen);
    check(seen, "R8", "done seen", seen, 1);
    check(!busy && !err && !bus_as, "R8", "idle after done", busy, 0);
    @(negedge clk);
    check(n_obs == n_exp, req, "beat count", n_obs, n_exp);
    ok = 1; bad_i = 0;
    for (int i = 0; i < n_exp && i < n_obs; i++)
      if (ok && (obs_addr[i] != exp_addr[i] || obs_bur[i] != exp_bur[i])) begin
        ok = 0; bad_i = i;
      end
    check(ok, "R3", "beat address/burst", obs_addr[bad_i], exp_addr[bad_i]);
    check(bur_idx + 1 == n_exp_bur, req, "burst count", bur_idx + 1, n_exp_bur);
    check(n_gap == n_exp_bur - 1, "R7", "gap count", n_gap, n_exp_bur - 1);
    ok = 1;
    for (int i = 0; i < n_gap; i++) if (obs_gap[i] != gap + 1) ok = 0;
    check(ok, "R7", "gap length", (n_gap > 0) ? obs_gap[0] : 0, gap + 1);
    ok = (n_loc == n_exp);
    for (int i = 0; i < n_loc && i < n_exp; i++)
      if (obs_loc[i] != exp_addr[i] - a) ok = 0;
    check(ok, "R11", "local offsets", n_loc, n_exp);
    mon_on = 1'b0;
  endtask

  task automatic t_reset();
    check(!busy && !done && !err && !bus_as && !bus_req && !loc_valid, "R1",
          "reset outputs", {busy, done, err, bus_as, bus_req, loc_valid}, 0);
  endtask

  task automatic t_count_cut();  // R6: 16 beats, 4 per burst
    ws = 0; berr_at = -1;
    run_and_compare("R6", 32'h1000, 64, 2, 4, 2);
  endtask

  task automatic t_page_cut();  // R5: cut at 0x1100 with no count limit
    ws = 0; berr_at = -1;
    run_and_compare("R5", 32'h10F0, 64, 2, 0, 0);
  endtask

  task automatic t_halfword_waits();  // R3 with wait states
    ws = 2; berr_at = -1;
    run_and_compare("R3", 32'h20FA, 20, 1, 3, 5);
  endtask

  task automatic t_long_bytes();  // R5: 256-byte maximum per burst
    ws = 0; berr_at = -1;
    run_and_compare("R5", 32'h3000, 600, 0, 0, 1);
  endtask

  task automatic t_bus_error();  // R9
    bit seen;
    ws = 0; berr_at = 5;
    arm_monitor();
    launch(32'h4000, 64, 2, 4, 1);
    wait_done(seen);
    check(seen && err, "R9", "error with done", err, 1);
    check(!busy && !bus_as && !bus_req, "R9", "bus released", bus_as, 0);
    @(negedge clk);
    check(n_obs == 5, "R9", "beats before abort", n_obs, 5);
    check(err, "R9", "err sticky", err, 1);
    mon_on = 1'b0; berr_at = -1;
  endtask

  task automatic t_zero_len();  // R10, also clears err from R9
    bit seen;
    arm_monitor();
    launch(32'h5000, 0, 2, 4, 1);
    check(done && !busy && !bus_as && !err, "R10", "instant done",
          {done, busy, bus_as, err}, 4'b1000);
    @(negedge clk);
    check(n_obs == 0 && !done, "R10", "no beats", n_obs, 0);
    mon_on = 1'b0;
    seen = 0;
  endtask

  task automatic t_start_busy();  // R12
    bit seen, ok;
    ws = 1; berr_at = -1;
    build_expect(32'h6000, 32, 2, 2);
    arm_monitor();
    launch(32'h6000, 32, 2, 2, 3);
    repeat (4) @(negedge clk);
    cfg_addr = 32'h7000; cfg_len = 16'd8; cfg_burst = 8'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    @(negedge clk);
    ok = (n_obs == n_exp);
    for (int i = 0; i < n_obs && i < n_exp; i++) if (obs_addr[i] != exp_addr[i]) ok = 0;
    check(ok, "R12", "second start ignored", n_obs, n_exp);
    check(!busy, "R12", "no extra transfer", busy, 0);
    mon_on = 1'b0;
  endtask

  initial begin
    mon_on = 1'b0; ws = 0; berr_at = -1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count_cut();
    t_page_cut();
    t_halfword_waits();
    t_long_bytes();
    t_bus_error();
    t_zero_len();
    t_start_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule